// File: doc/BRIEF.md
# Dual-Group Serial DAC Frame Writer

This block feeds two four-channel serial DAC chips from a waveform sequencer. Eight board channels are split into two groups: channels 0 to 3 sit on the first chip and are served by link 0, and channels 4 to 7 sit on the second chip and are served by link 1. Each group has its own request port. A request carries a 16-bit word, the channel index inside the chip (the board channel modulo 4), and a kind flag that says whether the word is an output value or a control-register word. The block turns that word into a 24-bit serial frame and shifts it out on the group's data line.

The two data lines share one serial clock and one active-low frame sync. For that reason a single frame engine paces both groups. Every word that is waiting when the engine goes idle is sent in the same frame, and a group with no word holds its data line low. A shared active-low load strobe makes all channels update together. The strobe is issued only when no frame is running or waiting. While the force-clear input is high, all five serial outputs are released to high impedance and all queued work is discarded.

Top module: `dac_frame_writer`

## Requirements
- R1: A word on group port g (g = board channel / 4) is shifted out on `dac_sdin[g]` only. A value word carries the in-chip index `req_selg` = board channel mod 4.
- R2: Frame for a value word (kind bit 0): bits 23..19 are 0, bit 18 is 0, bits 17..16 are the in-chip index, and bits 15..0 are the whole word.
- R3: Frame for a control word (kind bit 1): frame bits 21..19 take word bits 14..12, frame bits 18..16 take word bits 10..8 (so address 4 passes through as a broadcast), frame bits 3..0 take word bits 3..0, and every other frame bit is 0.
- R4: A frame is sent MSB first. `dac_sync_n` stays low for exactly 24*CLK_DIV clock cycles and `dac_sclk` gives 24 falling edges in that time. Each bit period starts with `dac_sclk` high for CLK_DIV/2 cycles. While sync is high, `dac_sclk` is low.
- R5: `busy[g]` goes high on the edge that samples an accepted start and falls on the edge where its frame ends. A start seen while `busy[g]` is high is ignored.
- R6: The words of both groups that are waiting when the engine is idle go out in one shared frame. A group that is not in a frame, or not in the current frame, keeps its data line at 0.
- R7: A word accepted while the engine is idle starts its frame on the next clock edge. A word accepted during a frame waits for the next frame.
- R8: A `load_req` pulse drives `dac_ldac_n` low for exactly CLK_DIV cycles. The strobe starts once no frame is active or waiting and never overlaps a low sync. When the engine is idle, the strobe starts two edges after the request. Repeated requests made before the strobe starts merge into one strobe.
- R9: While `force_clr` is 1, `dac_sclk`, `dac_sync_n`, both `dac_sdin` lines and `dac_ldac_n` are high impedance. Waiting words, the active frame and any waiting load are dropped, so `busy` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| force_clr | input | 1 | Tri-states the serial outputs and clears all work |
| req_start | input | 2 | Per-group start pulse |
| req_word0 | input | 16 | Data word for group 0 |
| req_word1 | input | 16 | Data word for group 1 |
| req_sel0 | input | 2 | In-chip channel index for group 0 |
| req_sel1 | input | 2 | In-chip channel index for group 1 |
| req_ctrl | input | 2 | Per-group kind: 1 = control word, 0 = value word |
| load_req | input | 1 | Request for a simultaneous output update |
| busy | output | 2 | Per-group word waiting or being shifted |
| dac_sclk | output | 1 | Shared serial clock (system clock / CLK_DIV) |
| dac_sync_n | output | 1 | Shared active-low frame sync |
| dac_sdin | output | 2 | Serial data, one line per group |
| dac_ldac_n | output | 1 | Shared active-low load strobe |

## Verification
A lane that has lost its waiting flag shows up at the link: its word never appears, or it appears a frame late. A receiver that checks each frame against the word accepted before launch catches this within one frame time, 24*CLK_DIV cycles. A wrong bit counter changes the sync low time and the number of clock falls, and this is visible when sync next rises. A load engine in the wrong state produces a strobe inside a frame, or one of the wrong length. Both show within CLK_DIV cycles of the strobe. A missing clear leaves the serial pins driven, or leaves `busy` high, on the cycle after `force_clr` is raised.

// File: rtl/dfw_pkg.sv
package dfw_pkg;

  localparam int FRAME_W = 24;

  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_LOAD  = 2'd2
  } eng_state_t;

  // Build one serial frame from a 16-bit word.
  function automatic frame_t dfw_frame(input logic [15:0] w,
                                       input logic [1:0]  sel,
                                       input logic        ctrl);
    frame_t f;
    f = '0;
    if (ctrl) begin
      f[21:19] = w[14:12];
      f[18:16] = w[10:8];
      f[3:0]   = w[3:0];
    end else begin
      f[17:16] = sel;
      f[15:0]  = w;
    end
    return f;
  endfunction

endpackage

// File: rtl/dfw_engine.sv
module dfw_engine
  import dfw_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic any_pend,
  input  logic load_req,
  output logic launch,
  output logic shift_step,
  output logic frame_done,
  output logic frame_active,
  output logic sclk_o,
  output logic sync_n_o,
  output logic ldac_n_o
);

  localparam int CW = $clog2(CLK_DIV);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST_C = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] HALF_C = CW'(CLK_DIV / 2);
  localparam logic [BW-1:0] TOP_B  = BW'(FRAME_W - 1);

  eng_state_t      state;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitn;
  logic            load_pend;
  logic            last_tick;

  assign last_tick    = (cnt == LAST_C);
  assign frame_active = (state == ENG_SHIFT);
  assign launch       = (state == ENG_IDLE) && any_pend && !clr;
  assign shift_step   = frame_active && last_tick && (bitn != '0);
  assign frame_done   = frame_active && last_tick && (bitn == '0);

  assign sync_n_o = !frame_active;
  assign sclk_o   = frame_active && (cnt < HALF_C);
  assign ldac_n_o = (state != ENG_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      load_pend <= 1'b0;
    end else if (clr) begin
      state     <= ENG_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      load_pend <= 1'b0;
    end else begin
      if (load_req) load_pend <= 1'b1;
      unique case (state)
        ENG_IDLE: begin
          cnt <= '0;
          if (any_pend) begin
            state <= ENG_SHIFT;
            bitn  <= TOP_B;
          end else if (load_pend) begin
            state     <= ENG_LOAD;
            load_pend <= 1'b0;
          end
        end
        ENG_SHIFT: begin
          cnt <= last_tick ? '0 : cnt + 1'b1;
          if (last_tick) begin
            if (bitn == '0) state <= ENG_IDLE;
            else            bitn  <= bitn - 1'b1;
          end
        end
        ENG_LOAD: begin
          cnt <= last_tick ? '0 : cnt + 1'b1;
          if (last_tick) state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dfw_lane.sv
module dfw_lane
  import dfw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        take,
  input  logic [15:0] word,
  input  logic [1:0]  sel,
  input  logic        ctrl,
  input  logic        launch,
  input  logic        step,
  input  logic        done,
  output logic        pend,
  output logic        busy,
  output logic        sd
);

  frame_t frame_q;
  logic   active;
  logic   accept;

  assign busy   = pend || active;
  assign accept = take && !busy;
  assign sd     = active ? frame_q[FRAME_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      pend    <= 1'b0;
      active  <= 1'b0;
    end else if (clr) begin
      pend    <= 1'b0;
      active  <= 1'b0;
    end else begin
      if (accept) begin
        frame_q <= dfw_frame(word, sel, ctrl);
        pend    <= 1'b1;
      end
      if (launch && pend) begin
        pend   <= 1'b0;
        active <= 1'b1;
      end
      if (active && step) frame_q <= frame_q << 1;
      if (active && done) active  <= 1'b0;
    end
  end

endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer
  import dfw_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        force_clr,
  input  logic [1:0]  req_start,
  input  logic [15:0] req_word0,
  input  logic [15:0] req_word1,
  input  logic [1:0]  req_sel0,
  input  logic [1:0]  req_sel1,
  input  logic [1:0]  req_ctrl,
  input  logic        load_req,
  output logic [1:0]  busy,
  output wire         dac_sclk,
  output wire         dac_sync_n,
  output wire  [1:0]  dac_sdin,
  output wire         dac_ldac_n
);

  localparam int GROUPS = 2;

  logic [15:0]       word_a [GROUPS];
  logic [1:0]        sel_a  [GROUPS];
  logic [GROUPS-1:0] pend_v;
  logic [GROUPS-1:0] busy_i;
  logic [GROUPS-1:0] sdin_i;
  logic              launch, shift_step, frame_done, frame_active;
  logic              sclk_i, sync_n_i, ldac_n_i;

  assign word_a[0] = req_word0;
  assign word_a[1] = req_word1;
  assign sel_a[0]  = req_sel0;
  assign sel_a[1]  = req_sel1;

  dfw_engine #(.CLK_DIV(CLK_DIV)) i_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (force_clr),
    .any_pend     (|pend_v),
    .load_req     (load_req),
    .launch       (launch),
    .shift_step   (shift_step),
    .frame_done   (frame_done),
    .frame_active (frame_active),
    .sclk_o       (sclk_i),
    .sync_n_o     (sync_n_i),
    .ldac_n_o     (ldac_n_i)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    dfw_lane i_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (force_clr),
      .take   (req_start[g]),
      .word   (word_a[g]),
      .sel    (sel_a[g]),
      .ctrl   (req_ctrl[g]),
      .launch (launch),
      .step   (shift_step),
      .done   (frame_done),
      .pend   (pend_v[g]),
      .busy   (busy_i[g]),
      .sd     (sdin_i[g])
    );
  end

  assign busy = busy_i;

  assign dac_sclk   = force_clr ? 1'bz  : sclk_i;
  assign dac_sync_n = force_clr ? 1'bz  : sync_n_i;
  assign dac_sdin   = force_clr ? 2'bzz : sdin_i;
  assign dac_ldac_n = force_clr ? 1'bz  : ldac_n_i;

endmodule

// File: rtl/dfw_checks.sv
module dfw_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       force_clr,
  input logic       sclk_i,
  input logic       sync_n_i,
  input logic       ldac_n_i,
  input logic [1:0] sdin_i,
  input logic [1:0] busy_i,
  input logic       frame_active,
  input logic       frame_done,
  input logic       launch
);

  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n_i |-> !sclk_i); // R4

  AST_FRAME_END_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_active) |-> ($past(frame_done) || $past(force_clr))); // R4

  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n_i |-> (sdin_i == 2'b00)); // R6

  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active |-> (busy_i != 2'b00)); // R5

  AST_LAUNCH_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (sync_n_i && ldac_n_i)); // R7

  AST_LOAD_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !ldac_n_i |-> sync_n_i); // R8

  AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    force_clr |=> (sync_n_i && ldac_n_i && (busy_i == 2'b00))); // R9

endmodule

bind dac_frame_writer dfw_checks i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .force_clr    (force_clr),
  .sclk_i       (sclk_i),
  .sync_n_i     (sync_n_i),
  .ldac_n_i     (ldac_n_i),
  .sdin_i       (sdin_i),
  .busy_i       (busy_i),
  .frame_active (frame_active),
  .frame_done   (frame_done),
  .launch       (launch)
);

// File: tb/test_dac_frame_writer.sv
`timescale 1ns/1ps
module test_dac_frame_writer;

  localparam int DIV = 8;

  typedef struct packed {
    logic [23:0] f;
    int          e;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        force_clr = 1'b0;
  logic [1:0]  req_start = '0;
  logic [15:0] req_word0 = '0, req_word1 = '0;
  logic [1:0]  req_sel0 = '0, req_sel1 = '0;
  logic [1:0]  req_ctrl = '0;
  logic        load_req = 1'b0;
  logic [1:0]  busy;
  wire         dac_sclk, dac_sync_n, dac_ldac_n;
  wire  [1:0]  dac_sdin;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  exp_t q0[$], q1[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dac_frame_writer #(.CLK_DIV(DIV)) i_dac_frame_writer (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_frame(input logic [15:0] w, input logic [1:0] s, input logic c);
    int unsigned x = w;
    if (c) return 24'((((x >> 12) & 7) << 19) | (((x >> 8) & 7) << 16) | (x & 15));
    return 24'(s * 65536 + x);
  endfunction

  // Serial receiver and strobe monitor
  bit in_frame = 0, prev_k = 0, part0 = 0, part1 = 0;
  int low_cnt = 0, nbits = 0, lcnt = 0;
  logic [23:0] rx0, rx1;
  always @(negedge clk) begin
    if (!rst_n || force_clr) begin
      in_frame = 0; prev_k = 0; lcnt = 0;
    end else begin
      if (!in_frame && dac_sync_n == 1'b0) begin
        in_frame = 1; low_cnt = 0; nbits = 0; rx0 = '0; rx1 = '0;
        part0 = (q0.size() > 0) && (q0[0].e < cyc);
        part1 = (q1.size() > 0) && (q1[0].e < cyc);
      end
      if (in_frame && dac_sync_n == 1'b0) begin
        low_cnt++;
        if (prev_k && dac_sclk == 1'b0) begin
          rx0 = {rx0[22:0], dac_sdin[0]};
          rx1 = {rx1[22:0], dac_sdin[1]};
          nbits++;
        end
      end else if (in_frame) begin
        in_frame = 0;
        chk(low_cnt == 24*DIV, "R4 sync low length", low_cnt, 24*DIV);
        chk(nbits == 24, "R4 clock falls per frame", nbits, 24);
        if (part0) begin
          chk(rx0 == q0[0].f, "R1/R2/R3 group0 frame", rx0, q0[0].f);
          chk(busy[0] == 1'b0, "R5 busy0 drops at frame end", busy[0], 0);
          void'(q0.pop_front());
        end else chk(rx0 == 0, "R6 idle group0 line", rx0, 0);
        if (part1) begin
          chk(rx1 == q1[0].f, "R1/R2/R3 group1 frame", rx1, q1[0].f);
          chk(busy[1] == 1'b0, "R5 busy1 drops at frame end", busy[1], 0);
          void'(q1.pop_front());
        end else chk(rx1 == 0, "R6 idle group1 line", rx1, 0);
      end
      if (dac_ldac_n == 1'b0) begin
        lcnt++;
        if (dac_sync_n !== 1'b1) chk(0, "R8 strobe during frame", dac_sync_n, 1);
      end else if (lcnt != 0) begin
        chk(lcnt == DIV, "R8 strobe length", lcnt, DIV);
        lcnt = 0;
      end
      prev_k = (dac_sclk == 1'b1);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] m, input logic [15:0] w0, input logic [15:0] w1,
                       input logic [1:0] s0, input logic [1:0] s1, input logic [1:0] c);
    req_word0 = w0; req_word1 = w1; req_sel0 = s0; req_sel1 = s1; req_ctrl = c;
    req_start = m;
    if (m[0] && !busy[0]) q0.push_back('{f: exp_frame(w0, s0, c[0]), e: cyc + 1});
    if (m[1] && !busy[1]) q1.push_back('{f: exp_frame(w1, s1, c[1]), e: cyc + 1});
    tick();
    req_start = '0;
  endtask

  task automatic drain();
    int n = 0;
    while ((busy != 0 || dac_sync_n !== 1'b1 || dac_ldac_n !== 1'b1 || lcnt != 0) && n < 5000) begin
      tick(); n++;
    end
    tick(2 * DIV + 4);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    chk(dac_sync_n === 1'b1 && dac_sclk === 1'b0 && dac_ldac_n === 1'b1, "R4 reset idle lines",
        {dac_sync_n, dac_sclk, dac_ldac_n}, 3'b101);
    chk(busy == 2'b00, "R5 reset busy", busy, 0);
    rst_n = 1'b1;
    tick(2);

    // R1 R2 R7: board channel 5 value word, launch timing
    issue(2'b10, 16'h0, 16'hA5C3, 2'd0, 2'd1, 2'b00);
    chk(busy == 2'b10, "R5 busy after accept", busy, 2'b10);
    chk(dac_sync_n === 1'b1, "R7 sync still high one edge after accept", dac_sync_n, 1);
    tick();
    chk(dac_sync_n === 1'b0, "R7 frame starts next edge", dac_sync_n, 0);
    // R5: ignored start while busy
    issue(2'b10, 16'h0, 16'h1111, 2'd0, 2'd3, 2'b00);
    drain();
    chk(q1.size() == 0, "R5 ignored start produced no frame", q1.size(), 0);

    // R3 broadcast control on group 0 with value word on group 1, shared frame (R6)
    issue(2'b11, 16'h9C4B, 16'h0102, 2'd0, 2'd2, 2'b01);
    drain();
    chk(q0.size() == 0 && q1.size() == 0, "R6 both groups in one frame", q0.size() + q1.size(), 0);

    // R7: word accepted during a frame waits for the next one
    issue(2'b01, 16'h00F0, 16'h0, 2'd3, 2'd0, 2'b00);
    tick(10);
    issue(2'b10, 16'h0, 16'h7FFF, 2'd0, 2'd0, 2'b10);
    chk(busy == 2'b11, "R7 second word waiting", busy, 2'b11);
    drain();

    // R8: load while idle, then load requested during a frame, merged requests
    load_req = 1'b1; tick(); load_req = 1'b0;
    chk(dac_ldac_n === 1'b1, "R8 strobe not yet low", dac_ldac_n, 1);
    tick();
    chk(dac_ldac_n === 1'b0, "R8 strobe low two edges after request", dac_ldac_n, 0);
    drain();
    issue(2'b01, 16'h1234, 16'h0, 2'd2, 2'd0, 2'b00);
    tick(5);
    load_req = 1'b1; tick(3); load_req = 1'b0;
    chk(dac_ldac_n === 1'b1, "R8 strobe held off during frame", dac_ldac_n, 1);
    drain();

    // R9: force clear mid frame
    issue(2'b11, 16'hBEEF, 16'hCAFE, 2'd1, 2'd2, 2'b00);
    tick(30);
    force_clr = 1'b1;
    tick();
    chk(dac_sclk === 1'bz && dac_sync_n === 1'bz && dac_sdin === 2'bzz && dac_ldac_n === 1'bz,
        "R9 outputs released", {dac_sclk, dac_sync_n, dac_sdin, dac_ldac_n}, 0);
    chk(busy == 2'b00, "R9 busy cleared", busy, 0);
    q0.delete(); q1.delete();
    force_clr = 1'b0;
    tick(2);
    chk(dac_sync_n === 1'b1 && dac_ldac_n === 1'b1, "R9 lines idle after clear",
        {dac_sync_n, dac_ldac_n}, 2'b11);

    // Random traffic
    for (int i = 0; i < 250; i++) begin
      issue(2'($urandom_range(0, 3)), 16'($urandom()), 16'($urandom()),
            2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      if ($urandom_range(0, 7) == 0) begin
        load_req = 1'b1; tick(); load_req = 1'b0;
      end
      tick($urandom_range(0, 220));
    end
    drain();
    chk(q0.size() == 0 && q1.size() == 0, "R6 all accepted words delivered", q0.size() + q1.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule